// File: doc/BRIEF.md
# Indirect Shared-RAM Access Port

This block gives a host processor indirect access to two word-wide memories, a communication RAM and a local-processor RAM, through five registers. The host loads a byte offset into a pointer register and then moves 16-bit words through a single data register. The two bytes of each word are exchanged on the way in and on the way out. Every data access advances the pointer by two bytes, so a run of data accesses walks the memory without reloading the pointer.

A control register picks which of the two memories the data register reaches. Writing the control register with its reset-command bit set clears both status registers at once. It then starts a background sweep that zeroes the first 32 bytes of the communication RAM, one word per clock. The host is held off while the sweep runs. Both memories sit outside the block and have a synchronous read port, so register and data reads are answered one cycle after they are accepted, with a valid strobe.

Top module: `shared_ram_window`

## Requirements
- R1: Only the low 8 address bits select a register: 0x00 control, 0x04 pointer, 0x08 data, 0x0C first status, 0x10 second status. Higher address bits have no effect.
- R2: A read of any other low-byte address returns 0xFFFFFFFF.
- R3: Control bit 0 steers data accesses: 0 reaches the communication RAM (comm port), 1 reaches the local RAM (local port). The unselected RAM is not enabled.
- R4: A data read returns, in bits 15:0, the stored word with its two bytes exchanged. Bits 31:16 are zero. The pointer then holds its old value plus 2.
- R5: A data write stores bits 15:0 of the written value with its two bytes exchanged. The pointer then holds its old value plus 2.
- R6: The pointer wraps modulo 2^16, so a data access at 0xFFFE leaves it at 0x0000.
- R7: hostRvalid is high for exactly one cycle, the cycle after each accepted read, and at no other time.
- R8: A control write with bit 5 set clears both status registers. Bit 5 is never stored, every other bit of 15:0 is kept, and the pointer is unchanged.
- R9: After such a write, busy is high for exactly 16 cycles, starting the next cycle. In those cycles comm-RAM word addresses 0 to 15 are written with zero, one per cycle. hostReady is low throughout, and the local RAM and comm words 16 and up are untouched.
- R10: The pointer and both status registers keep bits 15:0 of a write and read back zero-extended to 32 bits. All registers are 0 after reset.
- R11: The RAM word address of a data access is pointer bits 15:1, so an odd pointer reaches the same word as the even pointer below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 32 | Host register address |
| hostRd | input | 1 | Host read request |
| hostWr | input | 1 | Host write request |
| hostWdata | input | 32 | Host write data |
| hostReady | output | 1 | Request accepted this cycle when high |
| hostRdata | output | 32 | Read response data |
| hostRvalid | output | 1 | Read response valid |
| busy | output | 1 | Comm-RAM clear sweep running |
| commEn | output | 1 | Comm RAM enable |
| commWe | output | 1 | Comm RAM write enable |
| commAddr | output | 15 | Comm RAM word address |
| commWdata | output | 16 | Comm RAM write data |
| commRdata | input | 16 | Comm RAM read data, one cycle after enable |
| localEn | output | 1 | Local RAM enable |
| localWe | output | 1 | Local RAM write enable |
| localAddr | output | 15 | Local RAM word address |
| localWdata | output | 16 | Local RAM write data |
| localRdata | input | 16 | Local RAM read data, one cycle after enable |

## Verification
A data read from the communication RAM can be followed at once by a reset-command write. In that case the read's response is delivered in the same cycle that the clear sweep takes over the comm RAM port. The bench provokes this with a data read at word 0 followed, with no idle cycle, by a control write carrying the reset bit. It expects the response to carry the pre-clear content of word 0 byte-swapped. It also expects the 16-word sweep to zero that word and its neighbours afterwards. The bench counts the busy cycles, checks that the host is held off during them, and confirms that word 16 and the local RAM kept their values.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int WORD_W = 16;
  localparam logic [7:0] REG_CTRL  = 8'h00;
  localparam logic [7:0] REG_OFFS  = 8'h04;
  localparam logic [7:0] REG_DATA  = 8'h08;
  localparam logic [7:0] REG_STAT0 = 8'h0C;
  localparam logic [7:0] REG_STAT1 = 8'h10;
  localparam int RAMSEL_BIT = 0;
  localparam int RESET_BIT  = 5;

  typedef enum logic [2:0] {
    RS_NONE, RS_CTRL, RS_OFFS, RS_DATA, RS_STAT0, RS_STAT1
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrOffs;
    logic   wrStat0;
    logic   wrStat1;
    logic   dataRd;
    logic   dataWr;
    logic   clearStart;
    logic   clearWr;
    logic   rdAccept;
    rdSel_e rdSel;
  } strobe_t;

  function automatic logic [WORD_W-1:0] swapBytes(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/srw_control.sv
module srw_control
  import srw_pkg::*;
#(
  parameter int CLEAR_BYTES = 32,
  localparam int CLEAR_WORDS = CLEAR_BYTES / 2,
  localparam int CNT_W = (CLEAR_WORDS > 1) ? $clog2(CLEAR_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       regOfs,
  input  logic             hostRd,
  input  logic             hostWr,
  input  logic             resetReq,
  output strobe_t          stb,
  output logic             busy,
  output logic             hostReady,
  output logic [CNT_W-1:0] clearAddr
);
  logic             busyQ;
  logic [CNT_W-1:0] clrCnt;
  logic             accept;
  logic             isCtrl, isOffs, isData, isStat0, isStat1;

  always_comb begin
    isCtrl  = (regOfs == REG_CTRL);
    isOffs  = (regOfs == REG_OFFS);
    isData  = (regOfs == REG_DATA);
    isStat0 = (regOfs == REG_STAT0);
    isStat1 = (regOfs == REG_STAT1);
    accept  = (hostRd || hostWr) && !busyQ;
  end

  always_comb begin
    stb            = '0;
    stb.wrCtrl     = accept && hostWr && isCtrl;
    stb.wrOffs     = accept && hostWr && isOffs;
    stb.wrStat0    = accept && hostWr && isStat0;
    stb.wrStat1    = accept && hostWr && isStat1;
    stb.dataRd     = accept && hostRd && isData;
    stb.dataWr     = accept && hostWr && isData;
    stb.clearStart = accept && hostWr && isCtrl && resetReq;
    stb.clearWr    = busyQ;
    stb.rdAccept   = accept && hostRd;
    if (isCtrl)       stb.rdSel = RS_CTRL;
    else if (isOffs)  stb.rdSel = RS_OFFS;
    else if (isData)  stb.rdSel = RS_DATA;
    else if (isStat0) stb.rdSel = RS_STAT0;
    else if (isStat1) stb.rdSel = RS_STAT1;
    else              stb.rdSel = RS_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      clrCnt <= '0;
    end else if (stb.clearStart) begin
      busyQ  <= 1'b1;
      clrCnt <= '0;
    end else if (busyQ) begin
      if (clrCnt == CNT_W'(CLEAR_WORDS - 1)) busyQ <= 1'b0;
      else clrCnt <= clrCnt + CNT_W'(1);
    end
  end

  assign busy      = busyQ;
  assign hostReady = !busyQ;
  assign clearAddr = clrCnt;
endmodule

// File: rtl/srw_datapath.sv
module srw_datapath
  import srw_pkg::*;
#(
  parameter int HOST_DW = 32,
  parameter int OFFS_W  = 16,
  parameter int CNT_W   = 4,
  localparam int RAM_AW = OFFS_W - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [HOST_DW-1:0] hostWdata,
  input  logic [CNT_W-1:0]   clearAddr,
  output logic [HOST_DW-1:0] hostRdata,
  output logic               hostRvalid,
  output logic               commEn,
  output logic               commWe,
  output logic [RAM_AW-1:0]  commAddr,
  output logic [WORD_W-1:0]  commWdata,
  input  logic [WORD_W-1:0]  commRdata,
  output logic               localEn,
  output logic               localWe,
  output logic [RAM_AW-1:0]  localAddr,
  output logic [WORD_W-1:0]  localWdata,
  input  logic [WORD_W-1:0]  localRdata
);
  logic [WORD_W-1:0]  ctrlQ, stat0Q, stat1Q;
  logic [OFFS_W-1:0]  offsQ;
  logic [WORD_W-1:0]  wrWord, swappedWr;
  logic [RAM_AW-1:0]  wordAddr, clrAddrW;
  logic               ramSel, dataAcc;
  logic               rvalidQ, ramSelQ;
  rdSel_e             rdSelQ;
  logic [HOST_DW-1:0] regRdQ, regRdNext;
  logic [WORD_W-1:0]  rawWord;
  logic               unusedWdataHi;

  assign wrWord        = hostWdata[WORD_W-1:0];
  assign unusedWdataHi = ^hostWdata[HOST_DW-1:WORD_W];
  assign swappedWr     = swapBytes(wrWord);
  assign ramSel        = ctrlQ[RAMSEL_BIT];
  assign dataAcc       = stb.dataRd || stb.dataWr;
  assign wordAddr      = offsQ[OFFS_W-1:1];
  assign clrAddrW      = RAM_AW'(clearAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      offsQ  <= '0;
      stat0Q <= '0;
      stat1Q <= '0;
    end else begin
      if (stb.wrCtrl) ctrlQ <= wrWord & ~(WORD_W'(1) << RESET_BIT);
      if (stb.wrOffs) offsQ <= hostWdata[OFFS_W-1:0];
      else if (dataAcc) offsQ <= offsQ + OFFS_W'(2);
      if (stb.clearStart) begin
        stat0Q <= '0;
        stat1Q <= '0;
      end else begin
        if (stb.wrStat0) stat0Q <= wrWord;
        if (stb.wrStat1) stat1Q <= wrWord;
      end
    end
  end

  always_comb begin
    commEn     = (dataAcc && !ramSel) || stb.clearWr;
    commWe     = (stb.dataWr && !ramSel) || stb.clearWr;
    commAddr   = stb.clearWr ? clrAddrW : wordAddr;
    commWdata  = stb.clearWr ? '0 : swappedWr;
    localEn    = dataAcc && ramSel;
    localWe    = stb.dataWr && ramSel;
    localAddr  = wordAddr;
    localWdata = swappedWr;
  end

  always_comb begin
    case (stb.rdSel)
      RS_CTRL:  regRdNext = HOST_DW'(ctrlQ);
      RS_OFFS:  regRdNext = HOST_DW'(offsQ);
      RS_STAT0: regRdNext = HOST_DW'(stat0Q);
      RS_STAT1: regRdNext = HOST_DW'(stat1Q);
      RS_DATA:  regRdNext = '0;
      default:  regRdNext = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rvalidQ <= 1'b0;
      rdSelQ  <= RS_NONE;
      ramSelQ <= 1'b0;
      regRdQ  <= '0;
    end else begin
      rvalidQ <= stb.rdAccept;
      if (stb.rdAccept) begin
        rdSelQ  <= stb.rdSel;
        ramSelQ <= ramSel;
        regRdQ  <= regRdNext;
      end
    end
  end

  assign rawWord = ramSelQ ? localRdata : commRdata;

  always_comb begin
    if (!rvalidQ)                hostRdata = '0;
    else if (rdSelQ == RS_DATA)  hostRdata = HOST_DW'(swapBytes(rawWord));
    else                         hostRdata = regRdQ;
  end

  assign hostRvalid = rvalidQ;
endmodule

// File: rtl/shared_ram_window.sv
module shared_ram_window
  import srw_pkg::*;
#(
  parameter int HOST_AW     = 32,
  parameter int HOST_DW     = 32,
  parameter int OFFS_W      = 16,
  parameter int CLEAR_BYTES = 32,
  localparam int RAM_AW      = OFFS_W - 1,
  localparam int CLEAR_WORDS = CLEAR_BYTES / 2,
  localparam int CNT_W       = (CLEAR_WORDS > 1) ? $clog2(CLEAR_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostRd,
  input  logic               hostWr,
  input  logic [HOST_DW-1:0] hostWdata,
  output logic               hostReady,
  output logic [HOST_DW-1:0] hostRdata,
  output logic               hostRvalid,
  output logic               busy,
  output logic               commEn,
  output logic               commWe,
  output logic [RAM_AW-1:0]  commAddr,
  output logic [WORD_W-1:0]  commWdata,
  input  logic [WORD_W-1:0]  commRdata,
  output logic               localEn,
  output logic               localWe,
  output logic [RAM_AW-1:0]  localAddr,
  output logic [WORD_W-1:0]  localWdata,
  input  logic [WORD_W-1:0]  localRdata
);
  strobe_t          stb;
  logic [CNT_W-1:0] clearAddr;
  logic             unusedAddrHi;

  assign unusedAddrHi = ^hostAddr[HOST_AW-1:8];

  srw_control #(.CLEAR_BYTES(CLEAR_BYTES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regOfs    (hostAddr[7:0]),
    .hostRd    (hostRd),
    .hostWr    (hostWr),
    .resetReq  (hostWdata[RESET_BIT]),
    .stb       (stb),
    .busy      (busy),
    .hostReady (hostReady),
    .clearAddr (clearAddr)
  );

  srw_datapath #(.HOST_DW(HOST_DW), .OFFS_W(OFFS_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hostWdata  (hostWdata),
    .clearAddr  (clearAddr),
    .hostRdata  (hostRdata),
    .hostRvalid (hostRvalid),
    .commEn     (commEn),
    .commWe     (commWe),
    .commAddr   (commAddr),
    .commWdata  (commWdata),
    .commRdata  (commRdata),
    .localEn    (localEn),
    .localWe    (localWe),
    .localAddr  (localAddr),
    .localWdata (localWdata),
    .localRdata (localRdata)
  );
endmodule

// File: rtl/srw_checker.sv
module srw_checker
  import srw_pkg::*;
#(
  parameter int HOST_AW     = 32,
  parameter int HOST_DW     = 32,
  parameter int CLEAR_BYTES = 32,
  localparam int CLEAR_WORDS = CLEAR_BYTES / 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [HOST_AW-1:0] hostAddr,
  input logic               hostRd,
  input logic               hostWr,
  input logic [HOST_DW-1:0] hostWdata,
  input logic               hostReady,
  input logic [HOST_DW-1:0] hostRdata,
  input logic               hostRvalid,
  input logic               busy,
  input logic               commEn,
  input logic               commWe,
  input logic [WORD_W-1:0]  commWdata,
  input logic               localEn
);
  int   runLen;
  logic unmapped;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else runLen <= 0;
  end

  assign unmapped = !(hostAddr[7:0] inside {REG_CTRL, REG_OFFS, REG_DATA, REG_STAT0, REG_STAT1});

  AST_CLEAR_STARTED_BY_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(hostWr && hostReady && hostAddr[7:0] == REG_CTRL && hostWdata[RESET_BIT])); // R9
  AST_CLEAR_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runLen == CLEAR_WORDS); // R9
  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !hostReady); // R9
  AST_CLEAR_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (commEn && commWe && commWdata == '0 && !localEn)); // R9
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |-> $past(hostRd && hostReady)); // R7
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostReady) |=> hostRvalid); // R7
  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostReady && unmapped) |=> hostRdata == '1); // R2
  AST_ONE_RAM_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !(commEn && localEn)); // R3
  AST_NO_RD_WR_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    !(hostRd && hostWr)); // R1
endmodule

bind shared_ram_window srw_checker #(
  .HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .CLEAR_BYTES(CLEAR_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
  .hostWdata(hostWdata), .hostReady(hostReady), .hostRdata(hostRdata),
  .hostRvalid(hostRvalid), .busy(busy), .commEn(commEn), .commWe(commWe),
  .commWdata(commWdata), .localEn(localEn)
);

// File: tb/shared_ram_window_tb.sv
module shared_ram_window_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] hostAddr = '0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;
  logic [31:0] hostWdata = '0;
  logic        hostReady, hostRvalid, busy;
  logic [31:0] hostRdata;
  logic        commEn, commWe, localEn, localWe;
  logic [14:0] commAddr, localAddr;
  logic [15:0] commWdata, commRdata, localWdata, localRdata;

  logic [15:0] commMem [256];
  logic [15:0] localMem [256];

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  shared_ram_window u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostReady(hostReady), .hostRdata(hostRdata),
    .hostRvalid(hostRvalid), .busy(busy),
    .commEn(commEn), .commWe(commWe), .commAddr(commAddr), .commWdata(commWdata),
    .commRdata(commRdata), .localEn(localEn), .localWe(localWe), .localAddr(localAddr),
    .localWdata(localWdata), .localRdata(localRdata)
  );

  // RAM models: synchronous read, output only changes on a read
  always @(posedge clk) begin
    if (commEn) begin
      if (commWe) commMem[commAddr[7:0]] <= commWdata;
      else commRdata <= commMem[commAddr[7:0]];
    end
    if (localEn) begin
      if (localWe) localMem[localAddr[7:0]] <= localWdata;
      else localRdata <= localMem[localAddr[7:0]];
    end
  end

  function automatic void check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  task automatic waitReady();
    while (!hostReady) @(negedge clk);
  endtask

  task automatic doWrite(input logic [31:0] addr, input logic [31:0] data);
    waitReady();
    hostAddr = addr; hostWdata = data; hostWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic doRead(input logic [31:0] addr, input logic [31:0] exp, input string tag);
    waitReady();
    expQ.push_back(exp);
    tagQ.push_back(tag);
    hostAddr = addr; hostRd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && hostRvalid) begin
      if (expQ.size() == 0) begin
        check("R7 unexpected rvalid", 32'h1, 32'h0);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(t, hostRdata, e);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("R7 watchdog expired", 32'h1, 32'h0);
    summary();
    $finish;
  end

  initial begin
    int busyCycles;
    for (int i = 0; i < 256; i++) begin
      commMem[i]  = 16'h1000 + 16'(i);
      localMem[i] = 16'h2000 + 16'(i);
    end
    commMem[8] = 16'h1234;
    commRdata = '0; localRdata = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 ready after reset", {31'b0, hostReady}, 32'h1);
    check("R9 idle after reset", {31'b0, busy}, 32'h0);
    doRead(32'h00, 32'h0, "R10 ctrl reset value");
    doRead(32'h04, 32'h0, "R10 pointer reset value");
    doRead(32'h0C, 32'h0, "R10 status0 reset value");
    doRead(32'h10, 32'h0, "R10 status1 reset value");
    // pointer register, zero-extension and address aliasing
    doWrite(32'h04, 32'hABCD0010);
    doRead(32'h04, 32'h10, "R10 pointer keeps low 16 bits");
    doRead(32'hFFFFFF04, 32'h10, "R1 high address bits ignored");
    doRead(32'h14, 32'hFFFFFFFF, "R2 unmapped 0x14");
    doRead(32'h84, 32'hFFFFFFFF, "R2 unmapped 0x84");
    doRead(32'h0A, 32'hFFFFFFFF, "R2 unmapped 0x0A");
    // data read and write on comm RAM
    doRead(32'h08, 32'h00003412, "R4 swapped read");
    doRead(32'h04, 32'h12, "R4 pointer +2 after read");
    doWrite(32'h108, 32'h5555AABB);
    check("R5 swapped store", {16'b0, commMem[9]}, 32'hBBAA);
    check("R1 aliased data address", {16'b0, commMem[9]}, 32'hBBAA);
    doRead(32'h04, 32'h14, "R5 pointer +2 after write");
    // odd pointer
    doWrite(32'h04, 32'h15);
    doRead(32'h08, 32'h0A10, "R11 odd pointer word");
    doRead(32'h04, 32'h17, "R11 pointer +2 from odd");
    // local RAM selection
    doWrite(32'h00, 32'h1);
    doWrite(32'h04, 32'h20);
    doRead(32'h08, 32'h1020, "R3 local read");
    doWrite(32'h08, 32'h5566);
    check("R3 local write", {16'b0, localMem[17]}, 32'h6655);
    check("R3 comm untouched", {16'b0, commMem[17]}, 32'h1011);
    doWrite(32'h00, 32'h0);
    // wrap
    doWrite(32'h04, 32'hFFFE);
    doRead(32'h08, 32'hFF10, "R6 read at top");
    doRead(32'h04, 32'h0, "R6 pointer wrapped");
    // status registers
    doWrite(32'h0C, 32'h12345678);
    doWrite(32'h10, 32'h9999BEEF);
    doRead(32'h0C, 32'h5678, "R10 status0 low half");
    doRead(32'h10, 32'hBEEF, "R10 status1 low half");
    // data read immediately followed by reset command
    doWrite(32'h04, 32'h0);
    doRead(32'h08, 32'h0010, "R9 pre-clear word returned");
    doWrite(32'h00, 32'h0000C0A1);
    busyCycles = 0;
    while (busy) begin
      busyCycles++;
      check("R9 stalled while busy", {31'b0, hostReady}, 32'h0);
      @(negedge clk);
    end
    check("R9 busy length", 32'(busyCycles), 32'd16);
    for (int i = 0; i < 16; i++) check("R9 word cleared", {16'b0, commMem[i]}, 32'h0);
    check("R9 word 16 kept", {16'b0, commMem[16]}, 32'h1010);
    check("R9 local kept", {16'b0, localMem[0]}, 32'h2000);
    doRead(32'h0C, 32'h0, "R8 status0 cleared");
    doRead(32'h10, 32'h0, "R8 status1 cleared");
    doRead(32'h00, 32'h0000C081, "R8 ctrl without bit 5");
    doRead(32'h04, 32'h2, "R8 pointer unchanged");
    repeat (3) @(negedge clk);
    check("R7 all reads answered", 32'(expQ.size()), 32'd0);
    summary();
    $finish;
  end
endmodule